// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a 32-bit processor core and serves it through one combinational read port and one clocked write port, both addressed by a small register number. It holds a packed status register (a live status byte plus a saved status byte), an older saved status byte, a condition flag, two saved program counters and two plain storage slots. Each register has its own read mask and its own packing.

The block also owns the stack pointers. The live stack pointer is exported to the general register file, which can write it back. Two banked copies are kept, one for the interrupt stack and one for the user stack. When a status write changes the stack-mode bit (status bit 7), the live pointer is saved into the bank being left and reloaded from the bank being entered. Reads and writes of the two stack-pointer registers reach either the live pointer or the banked copy, depending on the current mode.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every register reads 0, the stack-mode bit is 0 and `sp_live` is 0.
- R2: Reading register 0 (status) returns the saved status byte ANDed with 0xC1 in bits 15:8, the live status byte ANDed with 0xC0 in bits 7:0 with the condition flag in bit 0, and zeros above bit 15.
- R3: Writing register 0 loads the saved status byte from bits 15:8, the live status byte from bits 7:0 and the condition flag from bit 0.
- R4: A status write that changes bit 7 from 0 to 1 stores the live pointer into the interrupt bank and loads the live pointer from the user bank.
- R5: A status write that changes bit 7 from 1 to 0 stores the live pointer into the user bank and loads the live pointer from the interrupt bank.
- R6: Register 2 (interrupt SP) reads and writes the live pointer while the stack-mode bit is 0 and the interrupt bank otherwise. Register 3 (user SP) reads and writes the live pointer while the stack-mode bit is 1 and the user bank otherwise.
- R7: Registers 6 and 8 (saved PCs) store all 32 bits on write and read back with bit 0 cleared.
- R8: Register 7 (older saved status) stores bits 7:0 on write and reads back ANDed with 0xC1.
- R9: Register 1 reads the condition flag in bit 0, with all other bits 0. A write loads the flag from bit 0. This is the same flag that appears in bit 0 of the status read.
- R10: Registers 4 and 5 are plain 32-bit storage.
- R11: Register numbers 9 to 15 read as 0, and writes to them change no register.
- R12: `gr_sp_we` loads `sp_live` from `gr_sp_data` on the clock edge. A mode-changing status write in the same cycle takes priority and the swap result wins. A control-port write that reaches the live pointer in the same cycle also takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_rd_num | input | 4 | Read register number |
| cr_rd_data | output | 32 | Read data (combinational) |
| cr_wr_en | input | 1 | Write strobe |
| cr_wr_num | input | 4 | Write register number |
| cr_wr_data | input | 32 | Write data |
| sp_live | output | 32 | Live stack pointer to the general register file |
| gr_sp_we | input | 1 | General register file writes the live stack pointer |
| gr_sp_data | input | 32 | Value written by the general register file |

## Verification
Two writes can compete for the live stack pointer in the same cycle. One is a write from the general register file. The other is a status write that flips the stack mode, or a control-port write to whichever SP register currently maps to the live pointer. The bench raises `gr_sp_we` with a distinct value in the same cycle as each of these control writes, in both modes. It then reads every register and `sp_live` and compares them with a bench model that applies the swap-first and control-port-first priority.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
   localparam int CR_STAT   = 0;
   localparam int CR_COND   = 1;
   localparam int CR_ISP    = 2;
   localparam int CR_USP    = 3;
   localparam int CR_SLOT0  = 4;
   localparam int CR_NSLOT  = 2;
   localparam int CR_BPC    = 6;
   localparam int CR_BBSTAT = 7;
   localparam int CR_BBPC   = 8;
   localparam logic [7:0] STAT_RD_MASK = 8'hC0;
   localparam logic [7:0] SAVE_RD_MASK = 8'hC1;
   localparam int MODE_BIT = 7;
endpackage

// File: rtl/ctl_status_regs.sv
module ctl_status_regs
   import ctl_reg_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stat_we,
   input  logic            cond_we,
   input  logic            bbs_we,
   input  logic [XLEN-1:0] wdata,
   output logic [7:0]      stat_q,
   output logic [7:0]      bbstat_q,
   output logic            cond_q,
   output logic [XLEN-1:0] stat_rd
);
   logic [7:0] bstat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q   <= '0;
         bstat_q  <= '0;
         bbstat_q <= '0;
         cond_q   <= 1'b0;
      end else begin
         if (stat_we) begin
            stat_q  <= wdata[7:0];
            bstat_q <= wdata[15:8];
         end
         if (stat_we || cond_we) cond_q <= wdata[0];
         if (bbs_we) bbstat_q <= wdata[7:0];
      end
   end

   always_comb begin
      stat_rd        = '0;
      stat_rd[15:8]  = bstat_q & SAVE_RD_MASK;
      stat_rd[7:0]   = (stat_q & STAT_RD_MASK) | {7'd0, cond_q};
   end

   // R9
   cond_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we || cond_we) |=> cond_q == $past(wdata[0]));

   // R3
   stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> stat_rd[15:8] == ($past(wdata[15:8]) & SAVE_RD_MASK));
endmodule

// File: rtl/ctl_sp_bank.sv
module ctl_sp_bank #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_q,
   input  logic            stat_we,
   input  logic            new_mode,
   input  logic            isp_we,
   input  logic            usp_we,
   input  logic [XLEN-1:0] wdata,
   input  logic            gr_we,
   input  logic [XLEN-1:0] gr_data,
   output logic [XLEN-1:0] live_q,
   output logic [XLEN-1:0] isp_rd,
   output logic [XLEN-1:0] usp_rd
);
   logic [XLEN-1:0] isp_q, usp_q;
   logic            flip, ctl_live_we;

   assign flip        = stat_we && (new_mode != mode_q);
   assign ctl_live_we = (isp_we && !mode_q) || (usp_we && mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         isp_q  <= '0;
         usp_q  <= '0;
      end else if (flip) begin
         if (mode_q) begin
            usp_q  <= live_q;
            live_q <= isp_q;
         end else begin
            isp_q  <= live_q;
            live_q <= usp_q;
         end
      end else begin
         if (ctl_live_we)       live_q <= wdata;
         else if (gr_we)        live_q <= gr_data;
         if (isp_we && mode_q)  isp_q  <= wdata;
         if (usp_we && !mode_q) usp_q  <= wdata;
      end
   end

   assign isp_rd = mode_q ? isp_q : live_q;
   assign usp_rd = mode_q ? live_q : usp_q;

   // R4
   swap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !mode_q && new_mode) |=>
         (isp_q == $past(live_q)) && (live_q == $past(usp_q)));

   // R5
   swap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && mode_q && !new_mode) |=>
         (usp_q == $past(live_q)) && (live_q == $past(isp_q)));

   // R12
   gr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gr_we && !flip && !ctl_live_we) |=> live_q == $past(gr_data));
endmodule

// File: rtl/ctl_slot_store.sv
module ctl_slot_store #(
   parameter int XLEN  = 32,
   parameter bit CLR0  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rd
);
   logic [XLEN-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

   generate
      if (CLR0) begin : g_clr
         assign rd = {q[XLEN-1:1], 1'b0};
      end else begin : g_raw
         assign rd = q;
      end
   endgenerate

   // R10
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
   import ctl_reg_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int NUM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_W-1:0] cr_rd_num,
   output logic [XLEN-1:0]  cr_rd_data,
   input  logic             cr_wr_en,
   input  logic [NUM_W-1:0] cr_wr_num,
   input  logic [XLEN-1:0]  cr_wr_data,
   output logic [XLEN-1:0]  sp_live,
   input  logic             gr_sp_we,
   input  logic [XLEN-1:0]  gr_sp_data
);
   localparam int NREG = 1 << NUM_W;

   generate
      if (XLEN < 16)     begin : g_bad_xlen $error("XLEN must be at least 16"); end
      if (NREG <= CR_BBPC) begin : g_bad_num $error("NUM_W too small for the map"); end
   endgenerate

   logic [NREG-1:0] wr_hit;
   always_comb begin
      wr_hit = '0;
      if (cr_wr_en) wr_hit[cr_wr_num] = 1'b1;
   end

   logic [7:0]      stat_q, bbstat_q;
   logic            cond_q;
   logic [XLEN-1:0] stat_rd, isp_rd, usp_rd, bpc_rd, bbpc_rd;
   logic [XLEN-1:0] slot_rd [CR_NSLOT];

   ctl_status_regs #(.XLEN(XLEN)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .stat_we(wr_hit[CR_STAT]), .cond_we(wr_hit[CR_COND]), .bbs_we(wr_hit[CR_BBSTAT]),
      .wdata(cr_wr_data), .stat_q(stat_q), .bbstat_q(bbstat_q),
      .cond_q(cond_q), .stat_rd(stat_rd));

   ctl_sp_bank #(.XLEN(XLEN)) u_sp (
      .clk(clk), .rst_n(rst_n), .mode_q(stat_q[MODE_BIT]),
      .stat_we(wr_hit[CR_STAT]), .new_mode(cr_wr_data[MODE_BIT]),
      .isp_we(wr_hit[CR_ISP]), .usp_we(wr_hit[CR_USP]), .wdata(cr_wr_data),
      .gr_we(gr_sp_we), .gr_data(gr_sp_data),
      .live_q(sp_live), .isp_rd(isp_rd), .usp_rd(usp_rd));

   ctl_slot_store #(.XLEN(XLEN), .CLR0(1'b1)) u_bpc (
      .clk(clk), .rst_n(rst_n), .we(wr_hit[CR_BPC]), .wdata(cr_wr_data), .rd(bpc_rd));

   ctl_slot_store #(.XLEN(XLEN), .CLR0(1'b1)) u_bbpc (
      .clk(clk), .rst_n(rst_n), .we(wr_hit[CR_BBPC]), .wdata(cr_wr_data), .rd(bbpc_rd));

   generate
      for (genvar i = 0; i < CR_NSLOT; i++) begin : g_slot
         ctl_slot_store #(.XLEN(XLEN), .CLR0(1'b0)) u_slot (
            .clk(clk), .rst_n(rst_n), .we(wr_hit[CR_SLOT0+i]),
            .wdata(cr_wr_data), .rd(slot_rd[i]));
      end
   endgenerate

   always_comb begin
      cr_rd_data = '0;
      case (int'(cr_rd_num))
         CR_STAT:    cr_rd_data = stat_rd;
         CR_COND:    cr_rd_data = XLEN'(cond_q);
         CR_ISP:     cr_rd_data = isp_rd;
         CR_USP:     cr_rd_data = usp_rd;
         CR_SLOT0:   cr_rd_data = slot_rd[0];
         CR_SLOT0+1: cr_rd_data = slot_rd[1];
         CR_BPC:     cr_rd_data = bpc_rd;
         CR_BBSTAT:  cr_rd_data = XLEN'(bbstat_q & SAVE_RD_MASK);
         CR_BBPC:    cr_rd_data = bbpc_rd;
         default:    cr_rd_data = '0;
      endcase
   end

   // R11
   unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cr_rd_num) > CR_BBPC) |-> cr_rd_data == '0);

   // R7
   bpc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cr_rd_num) == CR_BPC || int'(cr_rd_num) == CR_BBPC) |-> !cr_rd_data[0]);
endmodule

// File: tb/ctl_reg_bank_test.sv
module ctl_reg_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cr_rd_num = '0;
   logic [31:0] cr_rd_data;
   logic        cr_wr_en = 1'b0;
   logic [3:0]  cr_wr_num = '0;
   logic [31:0] cr_wr_data = '0;
   logic [31:0] sp_live;
   logic        gr_sp_we = 1'b0;
   logic [31:0] gr_sp_data = '0;

   int errors = 0, checks = 0;
   logic [7:0]  m_stat, m_bstat, m_bbstat;
   logic        m_cond;
   logic [31:0] m_live, m_isp, m_usp, m_bpc, m_bbpc, m_s4, m_s5;

   always #10 clk = ~clk;

   ctl_reg_bank uut (.*);

   initial begin
      #4_000_000;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   function automatic logic [31:0] exp_rd(int n);
      case (n)
         0: return {16'd0, m_bstat & 8'hC1, (m_stat & 8'hC0) | {7'd0, m_cond}};
         1: return {31'd0, m_cond};
         2: return m_stat[7] ? m_isp : m_live;
         3: return m_stat[7] ? m_live : m_usp;
         4: return m_s4;
         5: return m_s5;
         6: return {m_bpc[31:1], 1'b0};
         7: return {24'd0, m_bbstat & 8'hC1};
         8: return {m_bbpc[31:1], 1'b0};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag(int n);
      case (n)
         0: return "R2";  1: return "R9";  2, 3: return "R6";
         4, 5: return "R10"; 6, 8: return "R7"; 7: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic model_clear();
      m_stat = 0; m_bstat = 0; m_bbstat = 0; m_cond = 0;
      m_live = 0; m_isp = 0; m_usp = 0; m_bpc = 0; m_bbpc = 0; m_s4 = 0; m_s5 = 0;
   endtask

   task automatic model_step(bit we, int n, logic [31:0] d, bit gwe, logic [31:0] gd);
      bit flip, ctl_live;
      flip = we && n == 0 && (d[7] != m_stat[7]);
      ctl_live = we && ((n == 2 && !m_stat[7]) || (n == 3 && m_stat[7]));
      if (flip) begin
         if (m_stat[7]) begin m_usp = m_live; m_live = m_isp; end
         else           begin m_isp = m_live; m_live = m_usp; end
      end else begin
         if (ctl_live) m_live = d;
         else if (gwe) m_live = gd;
         if (we && n == 2 && m_stat[7])  m_isp = d;
         if (we && n == 3 && !m_stat[7]) m_usp = d;
      end
      if (we) case (n)
         0: begin m_stat = d[7:0]; m_bstat = d[15:8]; m_cond = d[0]; end
         1: m_cond = d[0];
         4: m_s4 = d;
         5: m_s5 = d;
         6: m_bpc = d;
         7: m_bbstat = d[7:0];
         8: m_bbpc = d;
         default: ;
      endcase
   endtask

   task automatic op(bit we, int n, logic [31:0] d, bit gwe, logic [31:0] gd);
      @(negedge clk);
      cr_wr_en = we; cr_wr_num = 4'(n); cr_wr_data = d;
      gr_sp_we = gwe; gr_sp_data = gd;
      @(negedge clk);
      cr_wr_en = 0; gr_sp_we = 0;
      model_step(we, n, d, gwe, gd);
   endtask

   task automatic check_all(string ctx);
      for (int n = 0; n < 16; n++) begin
         cr_rd_num = 4'(n);
         #0.5;
         checks++;
         if (cr_rd_data !== exp_rd(n)) begin
            errors++;
            $display("FAIL %s %s reg %0d: got %h expected %h", tag(n), ctx, n, cr_rd_data, exp_rd(n));
         end
      end
      checks++;
      if (sp_live !== m_live) begin
         errors++;
         $display("FAIL R12 %s sp_live: got %h expected %h", ctx, sp_live, m_live);
      end
   endtask

   initial begin
      logic [31:0] pat;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");
      // sweep: every register number with several patterns
      for (int p = 0; p < 6; p++) begin
         for (int n = 0; n < 16; n++) begin
            pat = 32'h9E37_79B9 * (p * 16 + n + 1) ^ {p[3:0], 28'h5A5_A5A5};
            op(1, n, pat, 0, 0);
            check_all("sweep R3 R10 R11");
         end
      end
      // mode toggling, R4 R5, with bank writes in each mode (R6)
      for (int k = 0; k < 8; k++) begin
         op(1, 2, 32'h1000_0000 + k, 0, 0);
         op(1, 3, 32'h2000_0000 + k, 0, 0);
         op(1, 0, {16'hFF00, (k % 2) ? 8'h81 : 8'h40}, 0, 0);
         check_all("swap R4 R5");
         op(1, 0, {16'h3C00, (k % 2) ? 8'h80 : 8'h01}, 0, 0);
         check_all("swap/no-swap R4 R5");
         op(0, 0, 0, 1, 32'hA500_0000 + k);
         check_all("gr write R12");
      end
      // collisions: gr write against mode flip and against control live write
      for (int k = 0; k < 4; k++) begin
         op(1, 0, {24'd0, (m_stat[7] ? 8'h00 : 8'h80)}, 1, 32'hDEAD_0000 + k);
         check_all("R12 flip beats gr");
         op(1, m_stat[7] ? 3 : 2, 32'hCAFE_0000 + k, 1, 32'hBEEF_0000 + k);
         check_all("R12 ctl beats gr");
         op(1, m_stat[7] ? 2 : 3, 32'h7777_0000 + k, 1, 32'h6666_0000 + k);
         check_all("R12 bank write plus gr");
         op(1, 0, {24'd0, m_stat[7], 7'h01}, 1, 32'h5555_0000 + k);
         check_all("R12 status no flip plus gr");
      end
      // reset again
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; model_clear();
      check_all("R1 second reset");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule